// File: doc/BRIEF.md
# Predicated Stateful Update Atom

This block owns a single state variable inside one stage of a packet pipeline and updates it atomically for every packet it accepts. In the same cycle it reads the state, evaluates four configurable relational tests and forms the new value. It then writes that value back, so the next packet, even one in the very next cycle, sees the result. The tests may compare the state itself, either packet field or a per-test constant. Three of the tests steer a two-level if/else tree that picks one of four update paths. The fourth test gates the write: when it is false the state keeps its value.

Each update path picks an operand: packet field 1, packet field 2 or its own constant. It then adds that operand to the state or subtracts it, and can force the result to zero instead. The pre-update and post-update state values leave the block one cycle after the packet enters, on a valid/ready output. Configuration pins are plain levels. Software changes them only while the block is idle or in reset. The initial state value is loaded on synchronous reset.

The input side follows valid/ready rules. A packet is taken on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so the unit sustains one packet per clock when the consumer never stalls. While the output is held by back-pressure, `in_ready` is low, no packet is taken and the state does not move. Held output values stay stable until taken.

Top module: `pred_state_atom`

## Requirements
- R1: Synchronous reset loads the state with `cfg_init` and empties the output (`out_valid` low, `in_ready` high). The first accepted packet reports `cfg_init` as its old value.
- R2: Each test applies a 3-bit operator code: 000 equal, 001 not equal, 010 less than, 011 less or equal, 100 greater than, 101 greater or equal, 110 always true, 111 always false. Comparisons are unsigned.
- R3: Each test takes its left and right operands through a 2-bit source code: 00 current state, 01 field 1, 10 field 2, 11 the test's own constant.
- R4: Tests are numbered 0 to 3 and paths 0 to 3. If test 0 holds, test 1 picks path 0 (true) or path 1 (false). If test 0 fails, test 2 picks path 2 (true) or path 3 (false).
- R5: When test 3 is false, the state is not changed and `out_new` equals `out_old`.
- R6: Each path takes its operand through a 2-bit code: 00 field 1, 01 field 2, 1x the path's constant.
- R7: A path's subtract bit selects state minus operand instead of state plus operand. Both wrap modulo 2^W.
- R8: A path's zero bit makes its result 0, whatever the arithmetic.
- R9: Every accepted packet sees the state left by the previous accepted packet, including at full rate, so no update is lost.
- R10: `in_ready` is low exactly when the output holds data that `out_ready` is not taking. While held, `out_valid`, `out_old` and `out_new` stay stable.
- R11: With all tests set to always true and path 0 adding constant 1, the unit counts up by one per accepted packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Packet present |
| in_ready | output | 1 | Packet can be taken this cycle |
| in_fld1 | input | W | Packet field 1 |
| in_fld2 | input | W | Packet field 2 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_old | output | W | State before this packet's update |
| out_new | output | W | State after this packet's update |
| cfg_init | input | W | State value loaded on reset |
| cfg_pop | input | 12 | Operator code of tests 0..3, 3 bits each, test 0 in the low bits |
| cfg_plhs | input | 8 | Left source code of tests 0..3, 2 bits each |
| cfg_prhs | input | 8 | Right source code of tests 0..3, 2 bits each |
| cfg_pconst | input | 4*W | Constant of tests 0..3 |
| cfg_usel | input | 8 | Operand code of paths 0..3, 2 bits each |
| cfg_usub | input | 4 | Subtract bit of paths 0..3 |
| cfg_uzero | input | 4 | Zero bit of paths 0..3 |
| cfg_uconst | input | 4*W | Constant of paths 0..3 |

## Verification
The bench sweeps all eight operator codes against the state, with fields chosen so that both outcomes occur. Swapping two codes, or using a signed compare, would produce a different branch and a wrong new value. It drives back-to-back packets at full rate, where a design with a stale state read would report the same old value twice and lose an increment. It stalls the consumer at random to catch a design that accepts a packet while the output is held, or lets held values change. Further runs reach wrap-around in both directions, a false write test that must leave the state alone, and the clear path.

// File: rtl/atom_pkg.sv
package atom_pkg;
  localparam int NUM_TEST = 4;
  localparam int NUM_PATH = 4;
  localparam int OP_W     = 3;
  localparam int SRC_W    = 2;
  localparam int PATH_W   = $clog2(NUM_PATH);

  typedef enum logic [OP_W-1:0] {
    REL_EQ    = 3'd0,
    REL_NE    = 3'd1,
    REL_LT    = 3'd2,
    REL_LE    = 3'd3,
    REL_GT    = 3'd4,
    REL_GE    = 3'd5,
    REL_TRUE  = 3'd6,
    REL_FALSE = 3'd7
  } rel_op_e;

  typedef enum logic [SRC_W-1:0] {
    CMP_STATE = 2'd0,
    CMP_FLD1  = 2'd1,
    CMP_FLD2  = 2'd2,
    CMP_CONST = 2'd3
  } cmp_src_e;
endpackage

// File: rtl/atom_pred.sv
module atom_pred
  import atom_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OP_W-1:0]  op,
  input  logic [SRC_W-1:0] lsel,
  input  logic [SRC_W-1:0] rsel,
  input  logic [W-1:0]     state,
  input  logic [W-1:0]     fld1,
  input  logic [W-1:0]     fld2,
  input  logic [W-1:0]     kval,
  output logic             hit
);
  logic [W-1:0] lhs, rhs;

  function automatic logic [W-1:0] pick(input logic [SRC_W-1:0] s,
                                        input logic [W-1:0] st,
                                        input logic [W-1:0] a,
                                        input logic [W-1:0] b,
                                        input logic [W-1:0] k);
    case (cmp_src_e'(s))
      CMP_STATE: pick = st;
      CMP_FLD1:  pick = a;
      CMP_FLD2:  pick = b;
      default:   pick = k;
    endcase
  endfunction

  always_comb begin
    lhs = pick(lsel, state, fld1, fld2, kval);
    rhs = pick(rsel, state, fld1, fld2, kval);
    case (rel_op_e'(op))
      REL_EQ:   hit = (lhs == rhs);
      REL_NE:   hit = (lhs != rhs);
      REL_LT:   hit = (lhs <  rhs);
      REL_LE:   hit = (lhs <= rhs);
      REL_GT:   hit = (lhs >  rhs);
      REL_GE:   hit = (lhs >= rhs);
      REL_TRUE: hit = 1'b1;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/atom_path.sv
module atom_path
  import atom_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [SRC_W-1:0] sel,
  input  logic             sub,
  input  logic             zero,
  input  logic [W-1:0]     state,
  input  logic [W-1:0]     fld1,
  input  logic [W-1:0]     fld2,
  input  logic [W-1:0]     kval,
  output logic [W-1:0]     result
);
  logic [W-1:0] opnd, sum, diff;

  always_comb begin
    if (sel[1])      opnd = kval;
    else if (sel[0]) opnd = fld2;
    else             opnd = fld1;
    sum  = state + opnd;
    diff = state - opnd;
    if (zero)     result = '0;
    else if (sub) result = diff;
    else          result = sum;
  end
endmodule

// File: rtl/atom_branch.sv
module atom_branch
  import atom_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [NUM_TEST-1:0]        hits,
  input  logic [NUM_PATH-1:0][W-1:0] results,
  input  logic [W-1:0]               state,
  output logic [PATH_W-1:0]          path,
  output logic [W-1:0]               next_val
);
  always_comb begin
    if (hits[0]) path = hits[1] ? PATH_W'(0) : PATH_W'(1);
    else         path = hits[2] ? PATH_W'(2) : PATH_W'(3);
    next_val = hits[3] ? results[path] : state;
  end
endmodule

// File: rtl/pred_state_atom.sv
module pred_state_atom
  import atom_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [W-1:0]              in_fld1,
  input  logic [W-1:0]              in_fld2,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [W-1:0]              out_old,
  output logic [W-1:0]              out_new,
  input  logic [W-1:0]              cfg_init,
  input  logic [NUM_TEST*OP_W-1:0]  cfg_pop,
  input  logic [NUM_TEST*SRC_W-1:0] cfg_plhs,
  input  logic [NUM_TEST*SRC_W-1:0] cfg_prhs,
  input  logic [NUM_TEST*W-1:0]     cfg_pconst,
  input  logic [NUM_PATH*SRC_W-1:0] cfg_usel,
  input  logic [NUM_PATH-1:0]       cfg_usub,
  input  logic [NUM_PATH-1:0]       cfg_uzero,
  input  logic [NUM_PATH*W-1:0]     cfg_uconst
);
  logic [W-1:0]               state_q;
  logic [NUM_TEST-1:0]        hits;
  logic [NUM_PATH-1:0][W-1:0] results;
  logic [PATH_W-1:0]          path;
  logic [W-1:0]               next_val;
  logic                       accept;

  for (genvar t = 0; t < NUM_TEST; t++) begin : g_test
    atom_pred #(.W(W)) pred_i (
      .op   (cfg_pop[t*OP_W +: OP_W]),
      .lsel (cfg_plhs[t*SRC_W +: SRC_W]),
      .rsel (cfg_prhs[t*SRC_W +: SRC_W]),
      .state(state_q),
      .fld1 (in_fld1),
      .fld2 (in_fld2),
      .kval (cfg_pconst[t*W +: W]),
      .hit  (hits[t])
    );
  end

  for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
    atom_path #(.W(W)) path_i (
      .sel   (cfg_usel[p*SRC_W +: SRC_W]),
      .sub   (cfg_usub[p]),
      .zero  (cfg_uzero[p]),
      .state (state_q),
      .fld1  (in_fld1),
      .fld2  (in_fld2),
      .kval  (cfg_uconst[p*W +: W]),
      .result(results[p])
    );
  end

  atom_branch #(.W(W)) branch_i (
    .hits    (hits),
    .results (results),
    .state   (state_q),
    .path    (path),
    .next_val(next_val)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= cfg_init;
      out_valid <= 1'b0;
      out_old   <= '0;
      out_new   <= '0;
    end else if (accept) begin
      state_q   <= next_val;
      out_valid <= 1'b1;
      out_old   <= state_q;
      out_new   <= next_val;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/atom_checker.sv
module atom_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_old,
  input logic [W-1:0] out_new,
  input logic [W-1:0] cfg_init
);
  logic         took_q;
  logic [W-1:0] last_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      took_q   <= 1'b0;
      last_new <= cfg_init;
    end else begin
      took_q <= in_valid && in_ready;
      if (took_q) last_new <= out_new;
    end
  end

  // R1: output empty right after reset
  a_r1_empty_after_reset: assert property (@(posedge clk)
    disable iff (rst) $fell(rst) |-> !out_valid);

  // R10: held output is not overwritten and does not change
  a_r10_stall_blocks: assert property (@(posedge clk)
    disable iff (rst) (out_valid && !out_ready) |-> !in_ready);

  a_r10_hold_stable: assert property (@(posedge clk)
    disable iff (rst) (out_valid && !out_ready) |=>
      (out_valid && $stable(out_old) && $stable(out_new)));

  // R9: each fresh result starts from the previous result's new value
  a_r9_chain: assert property (@(posedge clk)
    disable iff (rst) took_q |-> (out_old == last_new));
endmodule

bind pred_state_atom atom_checker #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_old  (out_old),
  .out_new  (out_new),
  .cfg_init (cfg_init)
);

// File: tb/pred_state_atom_tb.sv
module pred_state_atom_tb_top;
  localparam int  W = 16;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [W-1:0] in_fld1 = '0, in_fld2 = '0, out_old, out_new;
  logic [W-1:0] cfg_init;
  logic [11:0] cfg_pop;
  logic [7:0] cfg_plhs, cfg_prhs, cfg_usel;
  logic [4*W-1:0] cfg_pconst, cfg_uconst;
  logic [3:0] cfg_usub, cfg_uzero;

  // bench-side configuration
  int c_op[4], c_l[4], c_r[4], c_us[4];
  logic [W-1:0] c_pk[4], c_uk[4], c_init;
  bit c_sub[4], c_zero[4];

  always_comb begin
    cfg_init = c_init;
    for (int i = 0; i < 4; i++) begin
      cfg_pop[i*3 +: 3]    = c_op[i][2:0];
      cfg_plhs[i*2 +: 2]   = c_l[i][1:0];
      cfg_prhs[i*2 +: 2]   = c_r[i][1:0];
      cfg_pconst[i*W +: W] = c_pk[i];
      cfg_usel[i*2 +: 2]   = c_us[i][1:0];
      cfg_usub[i]          = c_sub[i];
      cfg_uzero[i]         = c_zero[i];
      cfg_uconst[i*W +: W] = c_uk[i];
    end
  end

  pred_state_atom #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_fld1(in_fld1), .in_fld2(in_fld2), .out_valid(out_valid),
    .out_ready(out_ready), .out_old(out_old), .out_new(out_new),
    .cfg_init(cfg_init), .cfg_pop(cfg_pop), .cfg_plhs(cfg_plhs),
    .cfg_prhs(cfg_prhs), .cfg_pconst(cfg_pconst), .cfg_usel(cfg_usel),
    .cfg_usub(cfg_usub), .cfg_uzero(cfg_uzero), .cfg_uconst(cfg_uconst)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what,
                     logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model
  logic [W-1:0] m_state, m_old, m_new;
  bit m_ov;

  function automatic bit rel(int op, logic [W-1:0] a, logic [W-1:0] b);
    case (op)
      0: return a == b;
      1: return a != b;
      2: return a < b;
      3: return a <= b;
      4: return a > b;
      5: return a >= b;
      6: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [W-1:0] src(int s, logic [W-1:0] f1,
                                       logic [W-1:0] f2, logic [W-1:0] k);
    if (s == 0) return m_state;
    if (s == 1) return f1;
    if (s == 2) return f2;
    return k;
  endfunction

  function automatic logic [W-1:0] model_next(logic [W-1:0] f1, logic [W-1:0] f2);
    bit h[4];
    int p;
    logic [W-1:0] opnd, v;
    for (int i = 0; i < 4; i++)
      h[i] = rel(c_op[i], src(c_l[i], f1, f2, c_pk[i]), src(c_r[i], f1, f2, c_pk[i]));
    if (!h[3]) return m_state;
    p = h[0] ? (h[1] ? 0 : 1) : (h[2] ? 2 : 3);
    opnd = (c_us[p] == 0) ? f1 : (c_us[p] == 1) ? f2 : c_uk[p];
    v = c_sub[p] ? m_state - opnd : m_state + opnd;
    if (c_zero[p]) v = '0;
    return v;
  endfunction

  task automatic defaults(logic [W-1:0] init);
    c_init = init;
    for (int i = 0; i < 4; i++) begin
      c_op[i] = 6; c_l[i] = 0; c_r[i] = 3; c_pk[i] = '0;
      c_us[i] = 2; c_uk[i] = W'(1); c_sub[i] = 1'b0; c_zero[i] = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_state = c_init; m_ov = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", W'(out_valid), '0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", W'(in_ready), W'(1));
  endtask

  task automatic run(int ncyc, string tag, int pv, int pr, int fmax);
    bit exp_rdy;
    logic [W-1:0] nv;
    repeat (ncyc) begin
      @(negedge clk);
      chk(out_valid == m_ov, "R10", "out_valid", W'(out_valid), W'(m_ov));
      if (m_ov) begin
        chk(out_old == m_old, {tag, "/R9"}, "out_old", out_old, m_old);
        chk(out_new == m_new, tag, "out_new", out_new, m_new);
      end
      in_valid  = ($urandom_range(0, 99) < pv);
      out_ready = ($urandom_range(0, 99) < pr);
      in_fld1   = (fmax < 0) ? W'($urandom) : W'($urandom_range(0, fmax));
      in_fld2   = (fmax < 0) ? W'($urandom) : W'($urandom_range(0, fmax));
      #1;
      exp_rdy = !m_ov || out_ready;
      chk(in_ready == exp_rdy, "R10", "in_ready", W'(in_ready), W'(exp_rdy));
      if (in_valid && exp_rdy) begin
        nv = model_next(in_fld1, in_fld2);
        m_old = m_state; m_new = nv; m_state = nv; m_ov = 1'b1;
      end else if (out_ready) begin
        m_ov = 1'b0;
      end
    end
  endtask

  initial begin
    defaults(W'(5));
    // R11: plain read-add-write counter
    do_reset();
    run(30, "R11", 100, 100, 7);

    // R2: every operator code, state against field 1
    for (int op = 0; op < 8; op++) begin
      defaults(W'(3));
      c_op[0] = op; c_l[0] = 0; c_r[0] = 1;
      c_zero[0] = 1'b1;
      do_reset();
      run(24, "R2", 90, 90, 7);
    end

    // R3: operand sources of the tests
    for (int k = 0; k < 6; k++) begin
      defaults(W'($urandom_range(0, 7)));
      c_op[0] = $urandom_range(0, 5);
      c_l[0] = $urandom_range(0, 3); c_r[0] = $urandom_range(0, 3);
      c_pk[0] = W'($urandom_range(0, 7));
      c_zero[0] = 1'b1;
      do_reset();
      run(20, "R3", 90, 90, 7);
    end

    // R4: branch nesting with distinct path effects
    for (int k = 0; k < 6; k++) begin
      defaults(W'(2));
      for (int i = 0; i < 3; i++) begin
        c_op[i] = $urandom_range(0, 7);
        c_l[i] = $urandom_range(0, 3); c_r[i] = $urandom_range(0, 3);
        c_pk[i] = W'($urandom_range(0, 9));
      end
      c_uk[0] = W'(1); c_uk[1] = W'(2); c_uk[2] = W'(3); c_zero[3] = 1'b1;
      do_reset();
      run(20, "R4", 90, 90, 9);
    end

    // R5: write test false leaves the state alone
    for (int k = 0; k < 4; k++) begin
      defaults(W'(4));
      c_op[3] = (k == 0) ? 7 : $urandom_range(0, 5);
      c_l[3] = 1; c_r[3] = 2;
      do_reset();
      run(20, "R5", 90, 90, 7);
    end

    // R6: path operand selection
    for (int k = 0; k < 4; k++) begin
      defaults(W'(1));
      for (int i = 0; i < 4; i++) begin
        c_us[i] = $urandom_range(0, 3);
        c_uk[i] = W'($urandom_range(0, 15));
      end
      do_reset();
      run(20, "R6", 90, 90, 15);
    end

    // R7: subtract and wrap in both directions
    defaults(W'(16'hFFFE));
    do_reset();
    run(12, "R7", 100, 100, 7);
    defaults(W'(1));
    c_sub[0] = 1'b1; c_us[0] = 2; c_uk[0] = W'(1);
    do_reset();
    run(12, "R7", 100, 100, 7);
    defaults(W'(16'h8000));
    c_sub[0] = 1'b1; c_us[0] = 0;
    do_reset();
    run(20, "R7", 100, 100, -1);

    // R8: clear path
    for (int k = 0; k < 4; k++) begin
      defaults(W'(9));
      c_op[0] = 2; c_l[0] = 1; c_r[0] = 3; c_pk[0] = W'(2);
      c_zero[0] = 1'b1; c_sub[0] = k[0]; c_us[0] = 0;
      do_reset();
      run(20, "R8", 90, 90, 7);
    end

    // R10: heavy back-pressure with random configuration
    for (int k = 0; k < 4; k++) begin
      defaults(W'($urandom));
      for (int i = 0; i < 4; i++) begin
        c_op[i] = $urandom_range(0, 7); c_l[i] = $urandom_range(0, 3);
        c_r[i] = $urandom_range(0, 3); c_pk[i] = W'($urandom);
        c_us[i] = $urandom_range(0, 3); c_uk[i] = W'($urandom);
        c_sub[i] = $urandom_range(0, 1); c_zero[i] = ($urandom_range(0, 3) == 0);
      end
      c_op[3] = 6;
      do_reset();
      run(40, "R10", 90, 30, -1);
    end

    // R9: full-rate random traffic
    for (int k = 0; k < 6; k++) begin
      defaults(W'($urandom_range(0, 31)));
      for (int i = 0; i < 4; i++) begin
        c_op[i] = $urandom_range(0, 7); c_l[i] = $urandom_range(0, 3);
        c_r[i] = $urandom_range(0, 3); c_pk[i] = W'($urandom_range(0, 31));
        c_us[i] = $urandom_range(0, 3); c_uk[i] = W'($urandom_range(0, 31));
        c_sub[i] = $urandom_range(0, 1); c_zero[i] = ($urandom_range(0, 5) == 0);
      end
      do_reset();
      run(50, "R9", 100, 100, 31);
    end

    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog run did not complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule